// File: doc/BRIEF.md
# Masked Vector Slice Extractor

This unit pulls one 128-bit or 256-bit slice out of a 256-bit or 512-bit source vector, with the slice picked by an 8-bit immediate index. It then applies a per-element writemask, at 32-bit or 64-bit element size, with either merge or zero behaviour, and forms a full 512-bit destination image. An execution pipeline uses it for vector extract operations that target either a register or a memory location.

In register form, every bit above the slice is cleared. In memory form, the unit drives a per-byte write enable so that masked-off elements and all bytes above the slice are left untouched in memory. The unit also checks two encoding conditions and raises an invalid-opcode flag when either fails; in that case the whole write is suppressed.

Each accepted input produces one registered result with a fixed latency of one cycle.

Top module: `vec_slice_extract`

## Requirements
- R1: With `src_wide`=0 and `slice_wide`=0, the slice is `src[127:0]` when `imm[0]`=0 and `src[255:128]` when `imm[0]`=1; `imm[7:1]` has no effect.
- R2: With `src_wide`=1 and `slice_wide`=0, `imm[1:0]`=k selects `src[128*k+127 : 128*k]`; `imm[7:2]` has no effect.
- R3: With `slice_wide`=1, `imm[0]` selects `src[255:0]` (0) or `src[511:256]` (1); `imm[7:1]` has no effect.
- R4: Element j (32 bits when `elem64`=0, 64 bits when 1) occupies `res[j*W +: W]` and is governed by `mask[j]`. There are 4/2 elements for a 128-bit slice and 8/4 for a 256-bit slice. Mask bits at or beyond that count have no effect.
- R5: In register form (`to_mem`=0), an element takes the extracted value when `legacy`=1, `mask_en`=0 or its mask bit is 1. Otherwise it becomes zero if `zeroing`=1, or keeps `old_dst` if `zeroing`=0.
- R6: In register form, result bits above the slice width up to bit 511 are 0, and `byte_en` is all zero.
- R7: In memory form (`to_mem`=1), masked-off elements keep `old_dst` whatever `zeroing` is. `byte_en[b]`=1 exactly for bytes b of elements that take the extracted value. Bytes above the slice have `byte_en`=0 and keep `old_dst` in `res`.
- R8: `bad_op` is 1 when `vvvv` is not 4'b1111.
- R9: `bad_op` is 1 when `legacy`=1 and `len_bit`=0. The legacy form always ignores the mask.
- R10: When `bad_op` is 1, `res` equals `old_dst` and `byte_en` is all zero.
- R11: `out_valid` is 1 exactly one cycle after a cycle with `in_valid`=1, and 0 otherwise. Synchronous reset clears `out_valid`, `res`, `byte_en` and `bad_op`. Without `in_valid`, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| src | input | 512 | Source vector (upper 256 bits unused for a 256-bit source) |
| imm | input | 8 | Slice index immediate |
| src_wide | input | 1 | 1: 512-bit source, 0: 256-bit source |
| slice_wide | input | 1 | 1: 256-bit slice, 0: 128-bit slice |
| elem64 | input | 1 | 1: 64-bit elements, 0: 32-bit elements |
| mask | input | 8 | Per-element writemask |
| mask_en | input | 1 | Writemask applies |
| zeroing | input | 1 | Masked-off elements become zero (register form) |
| old_dst | input | 512 | Previous destination contents |
| to_mem | input | 1 | 1: memory destination, 0: register destination |
| vvvv | input | 4 | Extra register specifier, must be 4'b1111 |
| legacy | input | 1 | Unmasked legacy 128-bit form |
| len_bit | input | 1 | Vector-length bit of the legacy form |
| out_valid | output | 1 | Result valid |
| res | output | 512 | Destination image |
| byte_en | output | 64 | Per-byte store enable (memory form) |
| bad_op | output | 1 | Invalid-opcode flag |

## Verification
For each accepted operation, the result, the byte enables and the invalid flag are all due exactly one rising edge after that operation is driven. `out_valid` is due on that same edge. The bench pushes its expected image into a queue when it drives an operation. It samples the outputs a short delay after the next rising edge and pops the entry there. On an idle cycle, it expects `out_valid` low and the previous outputs unchanged.

// File: rtl/vec_slice_extract.sv
`timescale 1ns/1ps
module vec_slice_extract (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [511:0] src,
  input  logic [7:0]   imm,
  input  logic         src_wide,
  input  logic         slice_wide,
  input  logic         elem64,
  input  logic [7:0]   mask,
  input  logic         mask_en,
  input  logic         zeroing,
  input  logic [511:0] old_dst,
  input  logic         to_mem,
  input  logic [3:0]   vvvv,
  input  logic         legacy,
  input  logic         len_bit,
  output logic         out_valid,
  output logic [511:0] res,
  output logic [63:0]  byte_en,
  output logic         bad_op
);
  logic [1:0]   q_idx;
  logic [127:0] narrow;
  logic [255:0] ext;
  logic [511:0] img;
  logic [63:0]  be;
  logic         bad;

  assign bad   = (vvvv != 4'hF) || (legacy && !len_bit);
  assign q_idx = src_wide ? imm[1:0] : {1'b0, imm[0]};

  always_comb begin
    case (q_idx)
      2'd0:    narrow = src[127:0];
      2'd1:    narrow = src[255:128];
      2'd2:    narrow = src[383:256];
      default: narrow = src[511:384];
    endcase
  end

  assign ext = slice_wide ? (imm[0] ? src[511:256] : src[255:0]) : {128'b0, narrow};

  genvar c;
  generate
    for (c = 0; c < 16; c++) begin : g_chunk
      if (c < 8) begin : g_lo
        logic       in_slice;
        logic [2:0] eidx;
        logic       take;
        assign in_slice = slice_wide || (c < 4);
        assign eidx     = elem64 ? 3'(c / 2) : 3'(c);
        assign take     = legacy || !mask_en || mask[eidx];
        always_comb begin
          if (bad) begin
            img[c*32 +: 32] = old_dst[c*32 +: 32];
            be[c*4 +: 4]    = 4'h0;
          end else if (!in_slice) begin
            img[c*32 +: 32] = to_mem ? old_dst[c*32 +: 32] : 32'b0;
            be[c*4 +: 4]    = 4'h0;
          end else if (take) begin
            img[c*32 +: 32] = ext[c*32 +: 32];
            be[c*4 +: 4]    = to_mem ? 4'hF : 4'h0;
          end else begin
            img[c*32 +: 32] = (!to_mem && zeroing) ? 32'b0 : old_dst[c*32 +: 32];
            be[c*4 +: 4]    = 4'h0;
          end
        end
      end else begin : g_hi
        assign img[c*32 +: 32] = (bad || to_mem) ? old_dst[c*32 +: 32] : 32'b0;
        assign be[c*4 +: 4]    = 4'h0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res       <= '0;
      byte_en   <= '0;
      bad_op    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res     <= img;
        byte_en <= be;
        bad_op  <= bad;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R11
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R11
  AST_REG_NO_BE: assert property (@(posedge clk) disable iff (rst) in_valid && !to_mem |=> byte_en == 64'b0); // R6
  AST_REG_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_valid && !to_mem && vvvv == 4'hF && !legacy && !slice_wide |=> res[511:128] == '0); // R6
  AST_MEM_HIGH_BE: assert property (@(posedge clk) disable iff (rst) in_valid && to_mem |=> byte_en[63:32] == 32'b0); // R7
  AST_BAD_SPEC: assert property (@(posedge clk) disable iff (rst)
    in_valid && vvvv != 4'hF |=> bad_op && res == $past(old_dst) && byte_en == 64'b0); // R8
  AST_BAD_LEN: assert property (@(posedge clk) disable iff (rst) in_valid && legacy && !len_bit |=> bad_op); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(res) && $stable(byte_en)); // R11
endmodule

// File: tb/sim_vec_slice_extract.sv
`timescale 1ns/1ps
module sim_vec_slice_extract;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [511:0] src = '0;
  logic [7:0]   imm = '0;
  logic         src_wide = 1'b0, slice_wide = 1'b0, elem64 = 1'b0;
  logic [7:0]   mask = '0;
  logic         mask_en = 1'b0, zeroing = 1'b0;
  logic [511:0] old_dst = '0;
  logic         to_mem = 1'b0;
  logic [3:0]   vvvv = 4'hF;
  logic         legacy = 1'b0, len_bit = 1'b1;
  logic         out_valid;
  logic [511:0] res;
  logic [63:0]  byte_en;
  logic         bad_op;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [511:0] q_res[$];
  logic [63:0]  q_be[$];
  logic         q_bad[$];
  string        q_tag[$];
  logic [511:0] last_res = '0;
  logic [63:0]  last_be = '0;

  always #2.5 clk = ~clk;

  vec_slice_extract u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .imm(imm),
    .src_wide(src_wide), .slice_wide(slice_wide), .elem64(elem64),
    .mask(mask), .mask_en(mask_en), .zeroing(zeroing), .old_dst(old_dst),
    .to_mem(to_mem), .vvvv(vvvv), .legacy(legacy), .len_bit(len_bit),
    .out_valid(out_valid), .res(res), .byte_en(byte_en), .bad_op(bad_op)
  );

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(output logic [511:0] r, output logic [63:0] be, output logic b);
    int sw, ew, n, base;
    bit take;
    b  = (vvvv != 4'hF) || (legacy && !len_bit);
    r  = to_mem ? old_dst : '0;
    be = '0;
    if (b) begin
      r = old_dst;
      return;
    end
    sw = slice_wide ? 256 : 128;
    ew = elem64 ? 64 : 32;
    n  = sw / ew;
    if (slice_wide)    base = imm[0] * 256;
    else if (src_wide) base = imm[1:0] * 128;
    else               base = imm[0] * 128;
    for (int j = 0; j < n; j++) begin
      take = legacy || !mask_en || mask[j];
      for (int k = 0; k < ew; k++) begin
        if (take)                  r[j*ew+k] = src[base + j*ew + k];
        else if (!to_mem && zeroing) r[j*ew+k] = 1'b0;
        else                       r[j*ew+k] = old_dst[j*ew+k];
      end
      if (take && to_mem)
        for (int q = 0; q < ew/8; q++) be[j*ew/8 + q] = 1'b1;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    if (q_res.size() > 0) begin
      string t;
      t = q_tag.pop_front();
      chk({t, " valid R11"}, {511'b0, out_valid}, 512'd1);
      chk({t, " res"}, res, q_res.pop_front());
      chk({t, " byte_en"}, {448'b0, byte_en}, {448'b0, q_be.pop_front()});
      chk({t, " bad_op"}, {511'b0, bad_op}, {511'b0, q_bad.pop_front()});
    end else begin
      chk("idle valid R11", {511'b0, out_valid}, 512'd0);
      chk("idle hold R11", res, last_res);
      chk("idle hold be R11", {448'b0, byte_en}, {448'b0, last_be});
    end
    last_res = res;
    last_be  = byte_en;
  endtask

  task automatic issue(string tag);
    logic [511:0] r;
    logic [63:0] be;
    logic b;
    model(r, be, b);
    in_valid = 1'b1;
    q_res.push_back(r);
    q_be.push_back(be);
    q_bad.push_back(b);
    q_tag.push_back(tag);
    tick();
    in_valid = 1'b0;
  endtask

  task automatic set_op(logic sw, logic slw, logic e64, logic [7:0] im, logic mem,
                        logic men, logic zr, logic [7:0] mk);
    src_wide = sw; slice_wide = slw; elem64 = e64; imm = im; to_mem = mem;
    mask_en = men; zeroing = zr; mask = mk; vvvv = 4'hF; legacy = 1'b0; len_bit = 1'b1;
  endtask

  task automatic fill();
    for (int i = 0; i < 16; i++) begin
      src[i*32 +: 32]     = $urandom;
      old_dst[i*32 +: 32] = $urandom;
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    fill();
    repeat (3) @(posedge clk);
    #2;
    chk("reset valid R11", {511'b0, out_valid}, 512'd0);
    chk("reset res R11", res, '0);
    chk("reset be/bad R11", {447'b0, bad_op, byte_en}, '0);
    rst = 1'b0;
    tick();

    set_op(0, 0, 0, 8'hFE, 0, 0, 0, 8'h00); issue("R1 imm0 high bits set");
    set_op(0, 0, 0, 8'h01, 0, 0, 0, 8'h00); issue("R1 imm1");
    for (int k = 0; k < 4; k++) begin
      fill();
      set_op(1, 0, 1, 8'(k) | 8'hA4 & 8'hFC, 0, 0, 0, 8'h00); issue("R2 quarter select");
    end
    set_op(1, 1, 0, 8'hF0, 0, 0, 0, 8'h00); issue("R3 low half");
    set_op(1, 1, 1, 8'h0F, 0, 0, 0, 8'h00); issue("R3 high half");
    tick();
    set_op(1, 0, 0, 8'h02, 0, 1, 0, 8'hF5); issue("R4 e32 mask high bits ignored");
    set_op(1, 0, 1, 8'h03, 0, 1, 1, 8'hFE); issue("R4 e64 mask high bits ignored");
    set_op(1, 1, 0, 8'h01, 0, 1, 0, 8'h5A); issue("R5 merge e32 wide");
    set_op(1, 1, 0, 8'h01, 0, 1, 1, 8'h5A); issue("R5 zero e32 wide");
    set_op(1, 1, 1, 8'h00, 0, 1, 1, 8'h06); issue("R5 zero e64 wide");
    set_op(0, 0, 0, 8'h01, 0, 1, 1, 8'h00); issue("R6 all masked reg");
    set_op(1, 0, 0, 8'h02, 1, 1, 0, 8'h09); issue("R7 mem merge e32");
    set_op(1, 0, 0, 8'h02, 1, 1, 1, 8'h09); issue("R7 mem zero flag ignored");
    set_op(1, 1, 1, 8'h01, 1, 1, 1, 8'h0A); issue("R7 mem wide e64");
    set_op(1, 1, 0, 8'h00, 1, 0, 0, 8'h00); issue("R7 mem unmasked");
    set_op(1, 0, 0, 8'h01, 0, 0, 0, 8'h00); vvvv = 4'hE; issue("R8 R10 bad vvvv reg");
    set_op(1, 0, 0, 8'h01, 1, 0, 0, 8'h00); vvvv = 4'h7; issue("R8 R10 bad vvvv mem");
    set_op(0, 0, 0, 8'h01, 0, 0, 0, 8'h00); legacy = 1; len_bit = 0; issue("R9 R10 legacy len0");
    set_op(0, 0, 0, 8'h01, 0, 1, 1, 8'h00); legacy = 1; len_bit = 1; issue("R9 legacy ignores mask");
    tick();
    tick();
    for (int i = 0; i < 300; i++) begin
      fill();
      set_op(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom), 8'($urandom));
      if ($urandom % 8 == 0) vvvv = 4'($urandom);
      if ($urandom % 6 == 0) begin legacy = 1; slice_wide = 0; src_wide = 0; len_bit = 1'($urandom); end
      if ($urandom % 5 == 0) tick();
      else issue("R4 R5 R7 random");
    end
    tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule